// File: doc/BRIEF.md
# Command List Processor

This block is the front end of a graphics register file. It walks a packed list of commands held in memory and turns each command into one or more register writes, each with a 4-bit byte enable. A host starts the first list with a one-cycle start pulse, a word address and a length in 32-bit words. The block then reads the list one word at a time through a simple request/response memory port and drives a registered write port.

Each packet in the list has three parts, in this order. First comes a data word. Next comes a header that names the target register, gives a byte mask and an extra-word count, and selects whether the extra words go to rising register indices or to a single index. The extra words follow. Packets always start on an 8-byte boundary, measured from the start of the current list.

The block watches its own writes for two chaining channels. Each channel has a size register and an address register. When a channel's trigger register is written, the current list is dropped and execution moves on to that channel's buffer with no help from the host. Writes to one chosen register index also raise an interrupt pulse.

Top module: `cmdlist_proc`

## Requirements
- R1: A packet is read in this order: the data word, then the header, then the extra words. Header bits 15:0 give the register index, bits 19:16 the byte mask, bits 30:20 the extra-word count and bit 31 the consecutive flag. The data word is written to the register index first.
- R2: Byte-mask bit i enables byte i of the write and appears unchanged on `wr_be_o`. The same mask applies to every write in the packet.
- R3: When the consecutive flag is 1, extra word k (counting from 1) is written to index + k. When the flag is 0, every extra word is written to the index itself.
- R4: Before a packet is fetched, the read pointer moves forward by one word if it lies an odd number of words from the start of the current list.
- R5: The list ends when the read pointer reaches the list start plus the length. At that point `done_o` pulses for one cycle and `busy_o` falls in the same cycle. `busy_o` is high from the cycle after an accepted start until then.
- R6: A packet whose byte mask is 0 still consumes all of its words but produces no write.
- R7: Channel c (c = 0, 1) has a size register at index 0x238+c and an address register at index 0x23A+c. Both are counted in 8-byte units and are updated only in the bytes that the write's mask enables. A write to trigger index 0x23C+c moves execution to word address 2×address, with a length of 2×size words.
- R8: A trigger write drops the rest of its own packet. Extra words that remain after the trigger write are neither fetched nor written.
- R9: `irq_o` pulses in the same cycle as a write to index `IRQ_INDEX`, and at no other time.
- R10: A start pulse that arrives while `busy_o` is high is ignored.
- R11: At most one memory read is outstanding. A request, together with its address, is held until it is accepted.
- R12: A trigger write in the last packet of a list takes priority over the end of that list. `done_o` is raised only when the chained buffer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new list |
| start_word_i | input | ADDR_W-2 | Word address of the list |
| start_len_i | input | SIZE_W+1 | List length in 32-bit words |
| busy_o | output | 1 | A list is being processed |
| done_o | output | 1 | One-cycle end-of-list pulse |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | ADDR_W | Byte address of the word to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Register write strobe |
| wr_index_o | output | 16 | Register index |
| wr_data_o | output | 32 | Write data |
| wr_be_o | output | 4 | Byte enables |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Two functions can fall on the same response cycle: a trigger write that redirects execution, and the end-of-list test or the fetch of the packet's next extra word. The bench builds a list whose last packet writes a trigger, so the end condition and the jump are both due at once. It also builds a list whose trigger packet still carries an extra word aimed at the other channel's trigger. In both cases the scoreboard expects the chained buffer's writes in order, with no write for the dropped word. A single done pulse must come only after the chained buffer ends.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

  localparam int IDX_W = 16;
  localparam int CNT_W = 11;
  localparam int BE_W  = 4;

  typedef struct packed {
    logic             consec;
    logic [CNT_W-1:0] extra;
    logic [BE_W-1:0]  mask;
    logic [IDX_W-1:0] index;
  } cmd_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DATA,
    ST_HDR,
    ST_EXT
  } seq_state_t;

endpackage

// File: rtl/cmdlist_fetch.sv
module cmdlist_fetch #(
  parameter int PTR_W = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [PTR_W+1:0]   req_addr_o,
  input  logic               rsp_valid_i,
  input  logic [31:0]        rsp_data_i,
  output logic               data_valid_o,
  output logic [31:0]        data_o
);

  logic             pend_q, pend_n;
  logic             outst_q, outst_n;
  logic [PTR_W-1:0] ptr_q;
  logic             ptr_en;

  assign req_valid_o  = pend_q;
  assign req_addr_o   = {ptr_q, 2'b00};
  assign data_valid_o = rsp_valid_i && outst_q;
  assign data_o       = rsp_data_i;

  always_comb begin
    pend_n  = pend_q;
    outst_n = outst_q;
    ptr_en  = 1'b0;
    if (pend_q && req_ready_i) begin
      pend_n  = 1'b0;
      outst_n = 1'b1;
    end
    if (data_valid_o) begin
      outst_n = 1'b0;
    end
    if (go_i) begin
      pend_n = 1'b1;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      outst_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      pend_q  <= pend_n;
      outst_q <= outst_n;
      if (ptr_en) begin
        ptr_q <= ptr_i;
      end
    end
  end

endmodule

// File: rtl/cmdlist_decode.sv
module cmdlist_decode
  import cmdlist_pkg::*;
#(
  parameter int MW = 28
) (
  input  logic [31:0]   word_i,
  output cmd_hdr_t      hdr_o,
  output logic [MW-1:0] bitmask_o
);

  assign hdr_o = cmd_hdr_t'(word_i);

  for (genvar b = 0; b < MW; b++) begin : g_bit
    assign bitmask_o[b] = hdr_o.mask[b/8];
  end

endmodule

// File: rtl/cmdlist_chan.sv
module cmdlist_chan #(
  parameter int          NCH     = 2,
  parameter int          SIZE_W  = 20,
  parameter int          CADDR_W = 28,
  parameter int          PTR_W   = 30,
  parameter logic [15:0] BASE    = 16'h0238,
  localparam int         LEN_W   = SIZE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [15:0]        wr_idx_i,
  input  logic [CADDR_W-1:0] wr_data_i,
  input  logic [CADDR_W-1:0] wr_bits_i,
  output logic               jump_o,
  output logic [PTR_W-1:0]   jump_head_o,
  output logic [LEN_W-1:0]   jump_len_o
);

  logic [NCH-1:0]            trig;
  logic [NCH-1:0][PTR_W-1:0] head_v;
  logic [NCH-1:0][LEN_W-1:0] len_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [15:0] SZ_IDX = BASE + 16'(c);
    localparam logic [15:0] AD_IDX = BASE + 16'(NCH + c);
    localparam logic [15:0] TR_IDX = BASE + 16'(2 * NCH + c);

    logic [SIZE_W-1:0]  size_q;
    logic [CADDR_W-1:0] addr_q;
    logic               size_en, addr_en;

    assign size_en = wr_en_i && (wr_idx_i == SZ_IDX);
    assign addr_en = wr_en_i && (wr_idx_i == AD_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q <= '0;
        addr_q <= '0;
      end else begin
        if (size_en) begin
          size_q <= (size_q & ~wr_bits_i[SIZE_W-1:0]) |
                    (wr_data_i[SIZE_W-1:0] & wr_bits_i[SIZE_W-1:0]);
        end
        if (addr_en) begin
          addr_q <= (addr_q & ~wr_bits_i) | (wr_data_i & wr_bits_i);
        end
      end
    end

    assign trig[c]   = wr_en_i && (wr_idx_i == TR_IDX);
    assign head_v[c] = PTR_W'({addr_q, 1'b0});
    assign len_v[c]  = {size_q, 1'b0};
  end

  assign jump_o = |trig;

  always_comb begin
    jump_head_o = '0;
    jump_len_o  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (trig[c]) begin
        jump_head_o = head_v[c];
        jump_len_o  = len_v[c];
      end
    end
  end

endmodule

// File: rtl/cmdlist_proc.sv
module cmdlist_proc
  import cmdlist_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          SIZE_W    = 20,
  parameter int          CADDR_W   = 28,
  parameter logic [15:0] IRQ_INDEX = 16'h0010,
  parameter logic [15:0] CHAN_BASE = 16'h0238,
  localparam int         PTR_W     = ADDR_W - 2,
  localparam int         LEN_W     = SIZE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  start_word_i,
  input  logic [LEN_W-1:0]  start_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_data_i,
  output logic              wr_valid_o,
  output logic [15:0]       wr_index_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_be_o,
  output logic              irq_o
);

  seq_state_t       state_q, state_n;
  logic [PTR_W-1:0] cur_q, cur_n, end_q, end_n, aligned;
  logic             cur_en, end_en;
  logic             par_q, par_n, par_en;
  logic [31:0]      data_q, hdr_q;
  logic             data_en, hdr_en;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             idx_en;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  logic             go;
  logic [PTR_W-1:0] go_ptr;
  logic             rd_valid;
  logic [31:0]      rd_data;

  logic [31:0]        hdr_word;
  cmd_hdr_t           dec;
  logic [CADDR_W-1:0] dec_bits;

  logic             wr_req;
  logic [IDX_W-1:0] wr_idx_c;
  logic [31:0]      wr_data_c;
  logic             done_n;

  logic             jump;
  logic [PTR_W-1:0] jump_head;
  logic [LEN_W-1:0] jump_len;

  logic             wr_valid_q, irq_q, done_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [31:0]      wr_data_q;
  logic [BE_W-1:0]  wr_be_q;

  cmdlist_fetch #(.PTR_W(PTR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .ptr_i        (go_ptr),
    .req_valid_o  (mem_req_valid_o),
    .req_ready_i  (mem_req_ready_i),
    .req_addr_o   (mem_req_addr_o),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_data_i   (mem_rsp_data_i),
    .data_valid_o (rd_valid),
    .data_o       (rd_data)
  );

  assign hdr_word = (state_q == ST_HDR) ? rd_data : hdr_q;

  cmdlist_decode #(.MW(CADDR_W)) u_decode (
    .word_i    (hdr_word),
    .hdr_o     (dec),
    .bitmask_o (dec_bits)
  );

  cmdlist_chan #(
    .NCH     (2),
    .SIZE_W  (SIZE_W),
    .CADDR_W (CADDR_W),
    .PTR_W   (PTR_W),
    .BASE    (CHAN_BASE)
  ) u_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_req),
    .wr_idx_i    (wr_idx_c),
    .wr_data_i   (wr_data_c[CADDR_W-1:0]),
    .wr_bits_i   (dec_bits),
    .jump_o      (jump),
    .jump_head_o (jump_head),
    .jump_len_o  (jump_len)
  );

  assign aligned = cur_q + PTR_W'(cur_q[0] ^ par_q);

  always_comb begin
    state_n   = state_q;
    cur_n     = cur_q;
    cur_en    = 1'b0;
    end_n     = end_q;
    end_en    = 1'b0;
    par_n     = par_q;
    par_en    = 1'b0;
    data_en   = 1'b0;
    hdr_en    = 1'b0;
    idx_n     = idx_q;
    idx_en    = 1'b0;
    cnt_n     = cnt_q;
    cnt_en    = 1'b0;
    go        = 1'b0;
    go_ptr    = cur_q;
    wr_req    = 1'b0;
    wr_idx_c  = idx_q;
    wr_data_c = rd_data;
    done_n    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cur_n   = start_word_i;
          cur_en  = 1'b1;
          end_n   = start_word_i + PTR_W'(start_len_i);
          end_en  = 1'b1;
          par_n   = start_word_i[0];
          par_en  = 1'b1;
          state_n = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cur_q >= end_q) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          go      = 1'b1;
          go_ptr  = aligned;
          cur_n   = aligned + PTR_W'(1);
          cur_en  = 1'b1;
          state_n = ST_DATA;
        end
      end
      ST_DATA: begin
        if (rd_valid) begin
          data_en = 1'b1;
          go      = 1'b1;
          go_ptr  = cur_q;
          cur_n   = cur_q + PTR_W'(1);
          cur_en  = 1'b1;
          state_n = ST_HDR;
        end
      end
      ST_HDR, ST_EXT: begin
        if (rd_valid) begin
          wr_req = |dec.mask;
          idx_en = 1'b1;
          cnt_en = 1'b1;
          if (state_q == ST_HDR) begin
            hdr_en    = 1'b1;
            wr_idx_c  = dec.index;
            wr_data_c = data_q;
            idx_n     = dec.index + IDX_W'(dec.consec);
            cnt_n     = dec.extra;
          end else begin
            idx_n = idx_q + IDX_W'(dec.consec);
            cnt_n = cnt_q - CNT_W'(1);
          end
          if (jump) begin
            cur_n   = jump_head;
            cur_en  = 1'b1;
            end_n   = jump_head + PTR_W'(jump_len);
            end_en  = 1'b1;
            par_n   = 1'b0;
            par_en  = 1'b1;
            state_n = ST_CHECK;
          end else if (cnt_n == '0) begin
            state_n = ST_CHECK;
          end else begin
            go      = 1'b1;
            go_ptr  = cur_q;
            cur_n   = cur_q + PTR_W'(1);
            cur_en  = 1'b1;
            state_n = ST_EXT;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      end_q      <= '0;
      par_q      <= 1'b0;
      data_q     <= '0;
      hdr_q      <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      wr_valid_q <= 1'b0;
      wr_idx_q   <= '0;
      wr_data_q  <= '0;
      wr_be_q    <= '0;
      irq_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_n;
      if (cur_en)  cur_q  <= cur_n;
      if (end_en)  end_q  <= end_n;
      if (par_en)  par_q  <= par_n;
      if (data_en) data_q <= rd_data;
      if (hdr_en)  hdr_q  <= rd_data;
      if (idx_en)  idx_q  <= idx_n;
      if (cnt_en)  cnt_q  <= cnt_n;
      wr_valid_q <= wr_req;
      if (wr_req) begin
        wr_idx_q  <= wr_idx_c;
        wr_data_q <= wr_data_c;
        wr_be_q   <= dec.mask;
      end
      irq_q  <= wr_req && (wr_idx_c == IRQ_INDEX);
      done_q <= done_n;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_index_o = wr_idx_q;
  assign wr_data_o  = wr_data_q;
  assign wr_be_o    = wr_be_q;
  assign irq_o      = irq_q;

endmodule

// File: rtl/cmdlist_proc_chk.sv
module cmdlist_proc_chk #(
  parameter int          ADDR_W    = 32,
  parameter logic [15:0] IRQ_INDEX = 16'h0010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              wr_valid_o,
  input logic [15:0]       wr_index_o,
  input logic [3:0]        wr_be_o,
  input logic              irq_o
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  p_no_empty_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_be_o != 4'b0000);

  p_irq_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> wr_valid_o && wr_index_o == IRQ_INDEX);

  p_irq_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_index_o == IRQ_INDEX |-> irq_o);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  p_write_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

endmodule

bind cmdlist_proc cmdlist_proc_chk #(.ADDR_W(ADDR_W), .IRQ_INDEX(IRQ_INDEX)) u_chk (.*);

// File: tb/cmdlist_proc_bench.sv
module cmdlist_proc_bench;

  localparam int          PTR_W   = 30;
  localparam int          LEN_W   = 21;
  localparam logic [15:0] IRQ_IDX = 16'h0010;

  typedef struct packed {
    logic [15:0] idx;
    logic [31:0] data;
    logic [3:0]  be;
  } wr_item_t;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [PTR_W-1:0]  start_word_i;
  logic [LEN_W-1:0]  start_len_i;
  logic              busy_o, done_o;
  logic              mem_req_valid_o, mem_req_ready_i;
  logic [31:0]       mem_req_addr_o;
  logic              mem_rsp_valid_i;
  logic [31:0]       mem_rsp_data_i;
  logic              wr_valid_o;
  logic [15:0]       wr_index_o;
  logic [31:0]       wr_data_o;
  logic [3:0]        wr_be_o;
  logic              irq_o;

  logic [31:0] mem [0:255];
  wr_item_t    exp_q[$];
  int          checks = 0;
  int          fails = 0;
  int          done_cnt = 0;
  int          overlaps = 0;
  bit          finished = 0;
  bit          tb_outst;
  logic [7:0]  acc_addr;
  int          rsp_wait;
  int          stall;

  cmdlist_proc u_cmdlist_proc (
    .clk, .rst_n, .start_i, .start_word_i, .start_len_i, .busy_o, .done_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o, .mem_rsp_valid_i,
    .mem_rsp_data_i, .wr_valid_o, .wr_index_o, .wr_data_o, .wr_be_o, .irq_o
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [15:0] idx, input logic [3:0] m,
                                      input logic [10:0] ext, input logic c);
    return {c, ext, m, idx};
  endfunction

  task automatic push(input logic [15:0] idx, input logic [31:0] data, input logic [3:0] be);
    exp_q.push_back('{idx: idx, data: data, be: be});
  endtask

  task automatic kick(input int word, input int len);
    start_word_i = PTR_W'(word);
    start_len_i  = LEN_W'(len);
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
  endtask

  // memory model: stalls acceptance, answers after 1 to 3 cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready_i <= 1'b0;
      mem_rsp_valid_i <= 1'b0;
      mem_rsp_data_i  <= '0;
      tb_outst        <= 1'b0;
      acc_addr        <= '0;
      rsp_wait        <= 0;
      stall           <= 0;
    end else begin
      mem_rsp_valid_i <= 1'b0;
      if (rsp_wait > 0) begin
        rsp_wait <= rsp_wait - 1;
        if (rsp_wait == 1) begin
          mem_rsp_valid_i <= 1'b1;
          mem_rsp_data_i  <= mem[acc_addr];
          tb_outst        <= 1'b0;
        end
      end
      if (mem_req_valid_o && mem_req_ready_i) begin
        acc_addr <= mem_req_addr_o[9:2];
        rsp_wait <= 1 + (stall % 3);
        tb_outst <= 1'b1;
      end
      stall           <= stall + 1;
      mem_req_ready_i <= (stall % 4) != 3;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 R6 unexpected write", {wr_index_o, wr_data_o}, 64'h0);
        end else begin
          wr_item_t e;
          e = exp_q.pop_front();
          check(wr_index_o == e.idx, "R1 R3 write index", 64'(wr_index_o), 64'(e.idx));
          check(wr_data_o == e.data, "R1 write data", 64'(wr_data_o), 64'(e.data));
          check(wr_be_o == e.be, "R2 byte enables", 64'(wr_be_o), 64'(e.be));
        end
        check(irq_o == (wr_index_o == IRQ_IDX), "R9 irq with write", 64'(irq_o),
              64'(wr_index_o == IRQ_IDX));
      end else if (irq_o) begin
        check(1'b0, "R9 irq without write", 64'(irq_o), 64'h0);
      end
      if (done_o) done_cnt++;
      if (mem_req_valid_o && tb_outst) begin
        overlaps++;
        check(1'b0, "R11 request while read outstanding", 64'(1), 64'(0));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    start_i      = 1'b0;
    start_word_i = '0;
    start_len_i  = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;

    // list 1 at word 0, 16 words
    mem[0]  = 32'h11223344;  mem[1]  = hdr(16'h0040, 4'hF, 11'd0, 1'b0);
    mem[2]  = 32'h0A0B0C0D;  mem[3]  = hdr(16'h0050, 4'h5, 11'd2, 1'b1);
    mem[4]  = 32'hE1E1E1E1;  mem[5]  = 32'hE2E2E2E2;
    mem[6]  = 32'h66666666;  mem[7]  = hdr(16'h0060, 4'h3, 11'd1, 1'b0);
    mem[8]  = 32'h88888888;  mem[9]  = 32'hDEADBEEF;
    mem[10] = hdr(16'h007E, 4'hF, 11'd0, 1'b0);
    mem[11] = hdr(16'h0070, 4'h0, 11'd1, 1'b0);
    mem[12] = 32'h12121212;
    mem[14] = 32'h0000CAFE;  mem[15] = hdr(IRQ_IDX, 4'h1, 11'd0, 1'b0);
    // list 2 at word 64, 8 words; chain buffer 0 at word 32
    mem[64] = 32'd3;         mem[65] = hdr(16'h0238, 4'hF, 11'd2, 1'b1);
    mem[66] = 32'd5;         mem[67] = 32'd16;
    mem[68] = 32'h77;        mem[69] = hdr(16'h023C, 4'hF, 11'd1, 1'b1);
    mem[70] = 32'h99;
    mem[32] = 32'hA0;        mem[33] = hdr(16'h0080, 4'hF, 11'd0, 1'b0);
    mem[34] = 32'hA1;        mem[35] = hdr(16'h0081, 4'hF, 11'd2, 1'b1);
    mem[36] = 32'hA2;        mem[37] = 32'hA3;
    // list 3 at word 96, 6 words; chain buffer 1 at word 48
    mem[96]  = 32'd1;        mem[97]  = hdr(16'h0239, 4'hF, 11'd0, 1'b0);
    mem[98]  = 32'hABCDEF18; mem[99]  = hdr(16'h023B, 4'h1, 11'd0, 1'b0);
    mem[100] = 32'd1;        mem[101] = hdr(16'h023D, 4'hF, 11'd0, 1'b0);
    mem[48]  = 32'hB0;       mem[49]  = hdr(16'h0090, 4'h8, 11'd0, 1'b0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0, "R5 reset busy", 64'(busy_o), 64'h0);
    check(done_o == 1'b0, "R5 reset done", 64'(done_o), 64'h0);
    check(wr_valid_o == 1'b0, "R1 reset write", 64'(wr_valid_o), 64'h0);
    check(mem_req_valid_o == 1'b0, "R11 reset request", 64'(mem_req_valid_o), 64'h0);
    check(irq_o == 1'b0, "R9 reset irq", 64'(irq_o), 64'h0);

    // run 1: decode, masks, both index modes, alignment, zero mask, irq
    push(16'h0040, 32'h11223344, 4'hF);
    push(16'h0050, 32'h0A0B0C0D, 4'h5);
    push(16'h0051, 32'hE1E1E1E1, 4'h5);
    push(16'h0052, 32'hE2E2E2E2, 4'h5);
    push(16'h0060, 32'h66666666, 4'h3);
    push(16'h0060, 32'h88888888, 4'h3);
    push(IRQ_IDX,  32'h0000CAFE, 4'h1);
    kick(0, 16);
    check(busy_o == 1'b1, "R5 busy after start", 64'(busy_o), 64'h1);
    repeat (8) @(negedge clk);
    kick(64, 8);                       // R10: must be ignored
    wait_done(1);
    check(busy_o == 1'b0, "R5 busy low with done", 64'(busy_o), 64'h0);
    check(exp_q.size() == 0, "R4 R6 R10 all run-1 writes seen", 64'(exp_q.size()), 64'h0);
    repeat (4) @(negedge clk);
    check(done_cnt == 1, "R5 single done pulse", 64'(done_cnt), 64'h1);

    // run 2: channel 0 setup and trigger that leaves an extra word behind
    push(16'h0238, 32'd3,  4'hF);
    push(16'h0239, 32'd5,  4'hF);
    push(16'h023A, 32'd16, 4'hF);
    push(16'h023C, 32'h77, 4'hF);
    push(16'h0080, 32'hA0, 4'hF);
    push(16'h0081, 32'hA1, 4'hF);
    push(16'h0082, 32'hA2, 4'hF);
    push(16'h0083, 32'hA3, 4'hF);
    kick(64, 8);
    wait_done(2);
    check(exp_q.size() == 0, "R7 R8 chained buffer writes", 64'(exp_q.size()), 64'h0);

    // run 3: masked address write, trigger is the last packet of the list
    push(16'h0239, 32'd1,        4'hF);
    push(16'h023B, 32'hABCDEF18, 4'h1);
    push(16'h023D, 32'd1,        4'hF);
    push(16'h0090, 32'hB0,       4'h8);
    kick(96, 6);
    wait_done(3);
    check(exp_q.size() == 0, "R12 R7 jump beats end of list", 64'(exp_q.size()), 64'h0);
    repeat (4) @(negedge clk);
    check(done_cnt == 3, "R12 one done per run", 64'(done_cnt), 64'h3);
    check(overlaps == 0, "R11 single outstanding read", 64'(overlaps), 64'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule